// File: doc/BRIEF.md
# Receive Pair Polarity Detector and Corrector

This block works out whether the receive twisted pair has been wired with its two conductors swapped. When it finds a swap, it inverts every received data bit before passing it downstream. It learns the wire polarity from reference pulses that an upstream pulse qualifier has already recognised. Each reference pulse arrives as a one-cycle strobe with a flag that says whether the pulse looked inverted on the raw wire.

With link integrity disabled, the block uses the idle pulse that closes each received packet as its reference. With link integrity enabled, it uses link pulses. Pulses from the source that is not selected are ignored. A single odd pulse does not change the decision. The block changes state only after a parameterised run of consecutive disagreeing pulses (two by default), and it commits the change only while no frame is on the wire.

A correction-enable input turns the whole function on or off. The current decision is also driven out as a level that can light a status LED.

Top module: `rx_polarity_fixer`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to the normal state. After that edge `pol_led` is 0 and `dout` equals `rx_bit`.
- R2: With `lnk_mode` = 1, only link pulses (`lp_stb`, `lp_rev`) are judged. With `lnk_mode` = 0, only idle pulses (`idl_stb`, `idl_rev`) are judged. Strobes from the other source leave the state and the disagreement count unchanged.
- R3: In the normal state, a judged pulse whose flag is 0 (correct on the raw wire) keeps the block in the normal state.
- R4: In the normal state, two consecutive judged pulses with flag 1 move the block to the reversed state. `pol_led` rises after the first clock edge that follows the second pulse, provided that edge sees `carrier` low and no judged strobe.
- R5: A judged pulse that agrees with the current state clears the disagreement count. A single disagreeing pulse followed by an agreeing one therefore never causes a change.
- R6: In the reversed state, `dout` is the bitwise inverse of `rx_bit` and `pol_led` is 1. In the normal state, `dout` equals `rx_bit` and `pol_led` is 0.
- R7: Flags always describe the raw wire. In the reversed state, a flag of 1 agrees with the state and a flag of 0 disagrees. Two consecutive flag-0 judged pulses return the block to the normal state.
- R8: A pending change of state is held while `carrier` is high. It is applied at the first edge where `carrier` is low and no judged strobe is present, so a frame is never partly inverted.
- R9: An agreeing judged pulse that arrives while a change is pending cancels that change.
- R10: While `corr_en` is 0, the state is forced to normal and the count is cleared. `dout` equals `rx_bit`, `pol_led` is 0, and pulses seen during this time have no later effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_en | input | 1 | Enables detection and correction |
| lnk_mode | input | 1 | 1 selects link pulses as the reference, 0 selects end-of-packet idle pulses |
| carrier | input | 1 | High while a frame is being received |
| idl_stb | input | 1 | One-cycle strobe for an end-of-packet idle pulse |
| idl_rev | input | 1 | 1 when that idle pulse looked inverted on the wire |
| lp_stb | input | 1 | One-cycle strobe for a link pulse |
| lp_rev | input | 1 | 1 when that link pulse looked inverted on the wire |
| rx_bit | input | DATA_W | Sampled receive data |
| dout | output | DATA_W | Polarity-corrected receive data |
| pol_led | output | 1 | 1 while the reversed state is in force |

## Verification
A wrong count or a wrong state shows up one clock after the pulse run completes. Either `pol_led` fails to rise or falls when it should not, and `dout` loses or gains inversion in the same cycle. A count that is not cleared by an agreeing pulse, or by a strobe from the other source, shows up only at the next pulse run: the block flips one pulse early. For that reason the bench interleaves agreeing, foreign and disagreeing pulses before each expected flip, and holds `carrier` high across a pending change to expose a mid-frame commit.

// File: rtl/rpf_pkg.sv
package rpf_pkg;

    typedef enum logic {
        POL_NORMAL   = 1'b0,
        POL_REVERSED = 1'b1
    } pol_state_t;

    typedef struct packed {
        logic valid;
        logic rev;
    } ref_pulse_t;

    function automatic pol_state_t pol_toggle(input pol_state_t s);
        return (s == POL_NORMAL) ? POL_REVERSED : POL_NORMAL;
    endfunction

    // A pulse disagrees when its raw-wire flag differs from the held decision
    function automatic logic ref_disagrees(input ref_pulse_t p, input pol_state_t s);
        return p.valid && (p.rev != (s == POL_REVERSED));
    endfunction

endpackage

// File: rtl/rpf_ref_select.sv
module rpf_ref_select
    import rpf_pkg::*;
(
    input  logic       lnk_mode,
    input  logic       idl_stb,
    input  logic       idl_rev,
    input  logic       lp_stb,
    input  logic       lp_rev,
    output ref_pulse_t ref_o
);
    always_comb begin
        if (lnk_mode) begin
            ref_o.valid = lp_stb;
            ref_o.rev   = lp_rev;
        end else begin
            ref_o.valid = idl_stb;
            ref_o.rev   = idl_rev;
        end
    end
endmodule

// File: rtl/rpf_judge.sv
module rpf_judge
    import rpf_pkg::*;
#(
    parameter int REV_COUNT = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       carrier,
    input  ref_pulse_t ref_i,
    input  pol_state_t cur_state,
    output logic       flip
);
    localparam int CW = $clog2(REV_COUNT + 1);
    localparam logic [CW-1:0] FULL = CW'(REV_COUNT);

    logic [CW-1:0] strikes;
    logic          disagree;

    assign disagree = ref_disagrees(ref_i, cur_state);
    // Commit only in a quiet gap with no reference pulse being judged
    assign flip = enable && !carrier && !ref_i.valid && (strikes == FULL);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            strikes <= '0;
        end else if (ref_i.valid) begin
            if (!disagree)
                strikes <= '0;
            else if (strikes != FULL)
                strikes <= strikes + 1'b1;
        end else if (flip) begin
            strikes <= '0;
        end
    end
endmodule

// File: rtl/rpf_invert.sv
module rpf_invert
    import rpf_pkg::*;
#(
    parameter int DATA_W = 1
) (
    input  logic [DATA_W-1:0] din,
    input  pol_state_t        state,
    output logic [DATA_W-1:0] dout
);
    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign dout[g] = din[g] ^ (state == POL_REVERSED);
    end
endmodule

// File: rtl/rx_polarity_fixer.sv
module rx_polarity_fixer
    import rpf_pkg::*;
#(
    parameter int DATA_W    = 1,
    parameter int REV_COUNT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              corr_en,
    input  logic              lnk_mode,
    input  logic              carrier,
    input  logic              idl_stb,
    input  logic              idl_rev,
    input  logic              lp_stb,
    input  logic              lp_rev,
    input  logic [DATA_W-1:0] rx_bit,
    output logic [DATA_W-1:0] dout,
    output logic              pol_led
);
    ref_pulse_t ref_p;
    pol_state_t state_q;
    logic       flip;

    rpf_ref_select u_sel (
        .lnk_mode (lnk_mode),
        .idl_stb  (idl_stb),
        .idl_rev  (idl_rev),
        .lp_stb   (lp_stb),
        .lp_rev   (lp_rev),
        .ref_o    (ref_p)
    );

    rpf_judge #(.REV_COUNT(REV_COUNT)) u_judge (
        .clk       (clk),
        .rst       (rst),
        .enable    (corr_en),
        .carrier   (carrier),
        .ref_i     (ref_p),
        .cur_state (state_q),
        .flip      (flip)
    );

    always_ff @(posedge clk) begin
        if (rst || !corr_en)
            state_q <= POL_NORMAL;
        else if (flip)
            state_q <= pol_toggle(state_q);
    end

    rpf_invert #(.DATA_W(DATA_W)) u_inv (
        .din   (rx_bit),
        .state (state_q),
        .dout  (dout)
    );

    assign pol_led = (state_q == POL_REVERSED);
endmodule

// File: rtl/rpf_chk.sv
module rpf_chk #(
    parameter int DATA_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              corr_en,
    input logic              lnk_mode,
    input logic              carrier,
    input logic              idl_stb,
    input logic              lp_stb,
    input logic [DATA_W-1:0] rx_bit,
    input logic [DATA_W-1:0] dout,
    input logic              pol_led
);
    // R1
    reset_normal_chk: assert property (@(posedge clk) rst |=> !pol_led);

    // R10
    disabled_normal_chk: assert property (@(posedge clk) disable iff (rst)
        !corr_en |=> !pol_led);

    // R8
    quiet_change_chk: assert property (@(posedge clk) disable iff (rst)
        (corr_en && $past(corr_en) && !$past(rst) && (pol_led != $past(pol_led)))
        |-> !$past(carrier));

    // R2
    no_flip_on_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (corr_en && ((lnk_mode && lp_stb) || (!lnk_mode && idl_stb)))
        |=> (pol_led == $past(pol_led)));

    // R6
    pass_normal_chk: assert property (@(posedge clk) disable iff (rst)
        !pol_led |-> (dout == rx_bit));

    // R6
    invert_reversed_chk: assert property (@(posedge clk) disable iff (rst)
        pol_led |-> (dout == ~rx_bit));
endmodule

bind rx_polarity_fixer rpf_chk #(.DATA_W(DATA_W)) u_rpf_chk (
    .clk      (clk),
    .rst      (rst),
    .corr_en  (corr_en),
    .lnk_mode (lnk_mode),
    .carrier  (carrier),
    .idl_stb  (idl_stb),
    .lp_stb   (lp_stb),
    .rx_bit   (rx_bit),
    .dout     (dout),
    .pol_led  (pol_led)
);

// File: tb/test_rx_polarity_fixer.sv
module test_rx_polarity_fixer;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic corr_en = 1'b0, lnk_mode = 1'b0, carrier = 1'b0;
    logic idl_stb = 1'b0, idl_rev = 1'b0, lp_stb = 1'b0, lp_rev = 1'b0;
    logic [0:0] rx_bit = 1'b0;
    logic [0:0] dout;
    logic pol_led;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rx_polarity_fixer i_rx_polarity_fixer (
        .clk(clk), .rst(rst), .corr_en(corr_en), .lnk_mode(lnk_mode),
        .carrier(carrier), .idl_stb(idl_stb), .idl_rev(idl_rev),
        .lp_stb(lp_stb), .lp_rev(lp_rev), .rx_bit(rx_bit),
        .dout(dout), .pol_led(pol_led)
    );

    // {en, lnk, is, ir, ls, lr, car, rx, exp_led, exp_dout}
    localparam int NV = 30;
    localparam logic [9:0] VEC [0:NV-1] = '{
        10'b1_0_10_00_0_1_0_1, // 0  R3 correct idle pulse
        10'b1_0_11_00_0_0_0_0, // 1  R5 one reversed
        10'b1_0_10_00_0_1_0_1, // 2  R5 agreeing clears
        10'b1_0_11_00_0_1_0_1, // 3  R5 one reversed
        10'b1_0_00_00_0_0_0_0, // 4  R5 no flip
        10'b1_0_00_11_0_1_0_1, // 5  R2 link pulse ignored
        10'b1_0_00_11_0_1_0_1, // 6  R2 link pulse ignored
        10'b1_0_00_00_0_1_0_1, // 7  R2 still normal
        10'b1_0_10_00_0_1_0_1, // 8  R5 clear
        10'b1_0_11_00_1_0_0_0, // 9  R4 first reversed in frame
        10'b1_0_11_00_1_1_0_1, // 10 R4 second reversed
        10'b1_0_00_00_1_1_0_1, // 11 R8 held during carrier
        10'b1_0_00_00_0_1_1_0, // 12 R8 committed in gap
        10'b1_0_00_00_0_0_1_1, // 13 R6 inverted
        10'b1_0_11_00_0_1_1_0, // 14 R7 flag 1 agrees
        10'b1_0_10_00_0_0_1_1, // 15 R7 one disagreeing
        10'b1_0_10_00_0_0_1_1, // 16 R9 pending
        10'b1_0_11_00_0_0_1_1, // 17 R9 agreeing cancels
        10'b1_0_00_00_0_0_1_1, // 18 R9 still reversed
        10'b1_1_00_10_0_1_1_0, // 19 R7 link flag 0
        10'b1_1_11_00_0_1_1_0, // 20 R2 idle ignored
        10'b1_1_00_10_0_1_1_0, // 21 R7 second link flag 0
        10'b1_1_00_00_0_1_0_1, // 22 R7 back to normal
        10'b1_1_00_11_0_1_0_1, // 23 R4 link reversed
        10'b1_1_00_11_0_1_0_1, // 24 R4 link reversed
        10'b1_1_00_00_0_1_1_0, // 25 R4 reversed
        10'b0_1_00_00_0_1_0_1, // 26 R10 disable forces normal
        10'b0_1_00_11_0_0_0_0, // 27 R10 pulse while disabled
        10'b0_1_00_11_0_0_0_0, // 28 R10 pulse while disabled
        10'b1_1_00_00_0_0_0_0  // 29 R10 no later effect
    };

    function automatic string row_tag(input int i);
        case (i)
            0: return "R3";
            1, 2, 3, 4, 8: return "R5";
            5, 6, 7, 20: return "R2";
            9, 10, 23, 24, 25: return "R4";
            11, 12: return "R8";
            13: return "R6";
            14, 15, 19, 21, 22: return "R7";
            16, 17, 18: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic apply(input logic en, input logic lnk, input logic is, input logic ir,
                         input logic ls, input logic lr, input logic car, input logic rx);
        @(negedge clk);
        corr_en = en; lnk_mode = lnk; idl_stb = is; idl_rev = ir;
        lp_stb = ls; lp_rev = lr; carrier = car; rx_bit = rx;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1 reset state
        apply(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R1", pol_led, 1'b0, "pol_led after reset");
        check("R1", dout[0], 1'b1, "dout after reset");
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [9:0] v;
            v = VEC[i];
            apply(v[9], v[8], v[7], v[6], v[5], v[4], v[3], v[2]);
            check(row_tag(i), pol_led, v[1], $sformatf("row %0d pol_led", i));
            check(row_tag(i), dout[0], v[0], $sformatf("row %0d dout", i));
        end

        // R4 reach reversed through link pulses, then R6 both data values
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4", pol_led, 1'b1, "reversed via link pulses");
        check("R6", dout[0], 1'b1, "inverted rx 0");
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        check("R6", dout[0], 1'b0, "inverted rx 1");

        // R1 reset from reversed state mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1", pol_led, 1'b0, "pol_led after mid-run reset");
        check("R1", dout[0], 1'b1, "dout after mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        apply(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1", pol_led, 1'b0, "count cleared by reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule